// File: doc/BRIEF.md
# DMA Stream Request Selector with Four-Phase Handshake

This block connects peripheral request lines to the streams of a DMA controller. Each of the eight streams has its own eight request inputs. A 3-bit select field per stream picks one of them as the stream's request source. The request lines are asynchronous to the controller clock, so each one passes through a two-flop synchronizer before it is selected.

For the selected source, each stream runs a four-phase handshake. A synchronized high request makes the stream raise a pending flag toward the arbiter. When the stream's data engine strobes that it has accessed the peripheral, the pending flag clears in that same cycle. The block then raises the acknowledge on that channel's return line only. The acknowledge stays high until the synchronized request is seen low. One released cycle follows before the stream may take a new request. This means a request held high through the acknowledge never counts as a second transfer.

The select field is captured only while the stream is disabled. Disabling a stream resets its handshake and drops its acknowledge.

Top module: `dma_req_selector`

## Requirements
- R1: Request input `req_in[s*8+c]` is channel c of stream s. Field `chan_sel[s*3+2 : s*3]` picks the channel that drives stream s. An unselected channel never raises that stream's pending flag.
- R2: Every request input passes through two synchronizer flops. A request raised between edges is not seen by the state machine until after the second rising edge. `req_pending` rises after the third rising edge.
- R3: A stream captures `chan_sel` on every rising edge where its enable is low. While the stream is enabled, changes to its select field have no effect until the stream has been disabled and enabled again.
- R4: `req_pending[s]` is high only while stream s waits for its access. It is low in any cycle where `access_done[s]` is high.
- R5: An `access_done[s]` strobe in the waiting state raises the acknowledge after the next rising edge. The acknowledge appears on `ack_out[s*8+c]` for the captured channel c only; all other acknowledge bits of the stream stay low.
- R6: The acknowledge stays high while the synchronized selected request is high. It goes low after the third rising edge that follows the request's fall.
- R7: A request that stays high through the acknowledge does not raise `req_pending` again. A new request is taken only after the acknowledge has been released.
- R8: After a rising edge with `stream_en[s]` low, stream s is idle, with its pending flag and all its acknowledge bits low.
- R9: Synchronous active-high `rst` clears all synchronizers, handshake states and captured selects. After reset, every output is low.
- R10: An `access_done[s]` strobe is ignored when stream s is not waiting for an access. No acknowledge results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 64 | Asynchronous peripheral requests, bit s*8+c = stream s channel c |
| stream_en | input | 8 | Per-stream enable |
| chan_sel | input | 24 | Per-stream 3-bit channel select, bits s*3 upward |
| access_done | input | 8 | Per-stream strobe: data engine has accessed the peripheral |
| req_pending | output | 8 | Per-stream request toward the arbiter |
| ack_out | output | 64 | Acknowledge back to the peripherals, same layout as req_in |

## Verification
On every cycle, the embedded assertions check several properties. At most one acknowledge bit per stream is high. Pending and acknowledge are never high together. A disable always returns the stream to idle, and a done strobe while waiting always produces an acknowledge. The acknowledge is held while the request stays high, the captured select never moves while the stream is enabled, and the acknowledge state never leads straight back to waiting. The exact latency through the synchronizer, the one released cycle before a request is taken again, and the routing of the acknowledge to the captured channel can only be shown by the bench. It uses directed sequences for these and a cycle-accurate reference model under random peripheral behaviour.

// File: rtl/dma_sel_pkg.sv
package dma_sel_pkg;

    localparam int NUM_STREAMS = 8;
    localparam int NUM_CH      = 8;
    localparam int CH_W        = $clog2(NUM_CH);

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_PEND = 2'd1,
        HS_ACK  = 2'd2,
        HS_REL  = 2'd3
    } hs_state_e;

    typedef struct packed {
        logic pending;
        logic ack;
    } hs_flags_t;

    function automatic hs_flags_t state_flags(hs_state_e st, logic done);
        hs_flags_t f;
        f.pending = (st == HS_PEND) && !done;
        f.ack     = (st == HS_ACK);
        return f;
    endfunction

endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stable_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_in;
            stable_q <= meta_q;
        end
    end

    assign sync_out = stable_q;

endmodule

// File: rtl/stream_handshake.sv
module stream_handshake
    import dma_sel_pkg::*;
#(
    parameter int CHANNELS = NUM_CH,
    parameter int SEL_W    = $clog2(CHANNELS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [SEL_W-1:0]    sel_in,
    input  logic [CHANNELS-1:0] req_vec,
    input  logic                access_done,
    output logic                pending,
    output logic [CHANNELS-1:0] ack_vec
);

    logic [SEL_W-1:0] sel_q;
    hs_state_e        st_q, st_d;
    hs_flags_t        flags;
    logic             sel_req;

    // Select is captured only while the stream is off
    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (!en)
            sel_q <= sel_in;
    end

    assign sel_req = req_vec[sel_q];

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = HS_IDLE;
        end else begin
            unique case (st_q)
                HS_IDLE: if (sel_req)     st_d = HS_PEND;
                HS_PEND: if (access_done) st_d = HS_ACK;
                HS_ACK:  if (!sel_req)    st_d = HS_REL;
                HS_REL:                   st_d = HS_IDLE;
                default:                  st_d = HS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= HS_IDLE;
        else
            st_q <= st_d;
    end

    assign flags   = state_flags(st_q, access_done);
    assign pending = flags.pending;

    always_comb begin
        ack_vec = '0;
        if (flags.ack)
            ack_vec[sel_q] = 1'b1;
    end

    // ---------------- assertions ----------------
    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ack_vec));

    assert_pend_ack_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(pending && (|ack_vec)));

    assert_done_gives_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q == HS_PEND && access_done && en) |=> (|ack_vec));

    assert_ack_held_R6: assert property (@(posedge clk) disable iff (rst)
        ((|ack_vec) && sel_req && en) |=> (|ack_vec));

    assert_no_rearm_R7: assert property (@(posedge clk) disable iff (rst)
        (st_q == HS_ACK) |=> (st_q != HS_PEND));

    assert_disable_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (st_q == HS_IDLE && !pending && ack_vec == '0));

    assert_sel_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        en |=> (!en || $stable(sel_q)));

endmodule

// File: rtl/dma_req_selector.sv
module dma_req_selector
    import dma_sel_pkg::*;
#(
    parameter int STREAMS  = NUM_STREAMS,
    parameter int CHANNELS = NUM_CH,
    localparam int SEL_W   = $clog2(CHANNELS),
    localparam int REQ_W   = STREAMS * CHANNELS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [REQ_W-1:0]         req_in,
    input  logic [STREAMS-1:0]       stream_en,
    input  logic [STREAMS*SEL_W-1:0] chan_sel,
    input  logic [STREAMS-1:0]       access_done,
    output logic [STREAMS-1:0]       req_pending,
    output logic [REQ_W-1:0]         ack_out
);

    logic [REQ_W-1:0] req_synced;

    req_sync #(.WIDTH(REQ_W)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (req_in),
        .sync_out (req_synced)
    );

    for (genvar s = 0; s < STREAMS; s++) begin : g_stream
        stream_handshake #(
            .CHANNELS (CHANNELS),
            .SEL_W    (SEL_W)
        ) u_hs (
            .clk         (clk),
            .rst         (rst),
            .en          (stream_en[s]),
            .sel_in      (chan_sel[s*SEL_W +: SEL_W]),
            .req_vec     (req_synced[s*CHANNELS +: CHANNELS]),
            .access_done (access_done[s]),
            .pending     (req_pending[s]),
            .ack_vec     (ack_out[s*CHANNELS +: CHANNELS])
        );
    end

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (req_pending == '0 && ack_out == '0));

endmodule

// File: tb/tb_dma_req_selector.sv
module tb_dma_req_selector;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 8;
    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [63:0]   req_in = '0;
    logic [7:0]    stream_en = '0;
    logic [23:0]   chan_sel = '0;
    logic [7:0]    access_done = '0;
    logic [7:0]    req_pending;
    logic [63:0]   ack_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit run_cmp  = 1'b0;

    // reference model state
    logic [63:0] m_s1 = '0, m_s2 = '0;
    int          m_st [NS];
    int          m_sel[NS];

    dma_req_selector dut (
        .clk(clk), .rst(rst), .req_in(req_in), .stream_en(stream_en),
        .chan_sel(chan_sel), .access_done(access_done),
        .req_pending(req_pending), .ack_out(ack_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // model: 0 idle, 1 waiting, 2 ack, 3 released
    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0;
            for (int s = 0; s < NS; s++) begin m_st[s] = 0; m_sel[s] = 0; end
        end else begin
            for (int s = 0; s < NS; s++) begin
                bit r;
                r = m_s2[s*NC + m_sel[s]];
                if (!stream_en[s]) m_st[s] = 0;
                else case (m_st[s])
                    0: if (r) m_st[s] = 1;
                    1: if (access_done[s]) m_st[s] = 2;
                    2: if (!r) m_st[s] = 3;
                    default: m_st[s] = 0;
                endcase
                if (!stream_en[s]) m_sel[s] = int'(chan_sel[s*3 +: 3]);
            end
            m_s2 = m_s1;
            m_s1 = req_in;
        end
    end

    function automatic logic [7:0] exp_pending();
        logic [7:0] v = '0;
        for (int s = 0; s < NS; s++) v[s] = (m_st[s] == 1) && !access_done[s];
        return v;
    endfunction

    function automatic logic [63:0] exp_ack();
        logic [63:0] v = '0;
        for (int s = 0; s < NS; s++) if (m_st[s] == 2) v[s*NC + m_sel[s]] = 1'b1;
        return v;
    endfunction

    always @(negedge clk) begin
        #2;
        if (run_cmp && !rst) begin
            check(req_pending == exp_pending(), "R4", "model pending",
                  {56'd0, req_pending}, {56'd0, exp_pending()});
            check(ack_out == exp_ack(), "R5", "model ack", ack_out, exp_ack());
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        cyc(3);
        rst = 1'b0;
        #1;
        // R9 reset state
        check(req_pending == 8'h00, "R9", "pending after reset", {56'd0, req_pending}, 64'd0);
        check(ack_out == 64'd0, "R9", "ack after reset", ack_out, 64'd0);
        run_cmp = 1'b1;

        // R10: done strobe on an idle enabled stream
        cyc(1); stream_en[0] = 1'b1;
        cyc(1); access_done[0] = 1'b1;
        cyc(1); access_done[0] = 1'b0; #1;
        check(ack_out == 64'd0 && req_pending == 8'd0, "R10", "stray done", ack_out, 64'd0);
        stream_en[0] = 1'b0;

        // stream 2 captures channel 5
        chan_sel[2*3 +: 3] = 3'd5;
        cyc(1); stream_en[2] = 1'b1;
        cyc(1); req_in[2*8+3] = 1'b1;           // unselected channel
        cyc(4); #1;
        check(req_pending[2] == 1'b0, "R1", "unselected channel", {63'd0, req_pending[2]}, 64'd0);

        cyc(1); req_in[2*8+5] = 1'b1;           // N0
        cyc(2); #1;                              // N2
        check(req_pending[2] == 1'b0, "R2", "pending before sync", {63'd0, req_pending[2]}, 64'd0);
        cyc(1); #1;                              // N3
        check(req_pending[2] == 1'b1, "R2", "pending after sync", {63'd0, req_pending[2]}, 64'd1);
        chan_sel[2*3 +: 3] = 3'd3;               // change while enabled
        access_done[2] = 1'b1; #1;
        check(req_pending[2] == 1'b0, "R4", "pending drops with done", {63'd0, req_pending[2]}, 64'd0);
        cyc(1); access_done[2] = 1'b0; #1;       // N4
        check(ack_out == (64'd1 << (2*8+5)), "R5", "ack on selected line", ack_out, 64'd1 << (2*8+5));
        for (int i = 0; i < 4; i++) begin
            cyc(1); #1;
            check(req_pending[2] == 1'b0, "R7", "held request not re-counted", {63'd0, req_pending[2]}, 64'd0);
            check(ack_out == (64'd1 << 21), "R6", "ack held", ack_out, 64'd1 << 21);
        end
        cyc(1); req_in[2*8+5] = 1'b0;            // drop
        cyc(2); #1;
        check(ack_out == (64'd1 << 21), "R6", "ack before sync of drop", ack_out, 64'd1 << 21);
        cyc(1); #1;
        check(ack_out == 64'd0, "R6", "ack released", ack_out, 64'd0);
        cyc(3); #1;
        check(req_pending[2] == 1'b0, "R3", "select change ignored", {63'd0, req_pending[2]}, 64'd0);
        cyc(1); stream_en[2] = 1'b0;
        cyc(1); stream_en[2] = 1'b1;
        cyc(1); #1;
        check(req_pending[2] == 1'b1, "R3", "new select after re-enable", {63'd0, req_pending[2]}, 64'd1);
        access_done[2] = 1'b1;
        cyc(1); access_done[2] = 1'b0; #1;
        check(ack_out == (64'd1 << (2*8+3)), "R5", "ack on new channel", ack_out, 64'd1 << 19);
        cyc(1); stream_en[2] = 1'b0;
        cyc(1); #1;
        check(ack_out == 64'd0 && req_pending == 8'd0, "R8", "disable drops ack", ack_out, 64'd0);

        // random phase against the model
        for (int t = 0; t < 4000; t++) begin
            cyc(1);
            for (int b = 0; b < 64; b++) begin
                if (ack_out[b]) begin
                    if ($urandom_range(1, 0) == 1) req_in[b] = 1'b0;
                end else if (!req_in[b]) begin
                    if ($urandom_range(9, 0) == 0) req_in[b] = 1'b1;
                end else if ($urandom_range(49, 0) == 0) req_in[b] = 1'b0;
            end
            for (int s = 0; s < NS; s++) begin
                if ($urandom_range(49, 0) == 0) stream_en[s] = ~stream_en[s];
                if ($urandom_range(19, 0) == 0) chan_sel[s*3 +: 3] = 3'($urandom_range(7, 0));
                access_done[s] = (m_st[s] == 1) ? ($urandom_range(2, 0) == 0)
                                                : ($urandom_range(19, 0) == 0);
            end
            if (t == 2000) stream_en = 8'hFF;
        end
        cyc(2);
        finish_run();
    end

endmodule